// File: doc/BRIEF.md
# Self-Routing Omega Network

This block is an N-input, N-output multistage interconnect (N a power of two) made of log2 N columns of 2×2 switching elements. A perfect-shuffle wiring feeds each column. Every input lane carries a valid flag, a destination index and a payload. The destination index travels with the payload through the network. Each element looks at one bit of that index and steers the request to its upper or lower output. No central controller is involved.

Two requests can reach the same element and ask for the same output. In that case the element lets one through and drops the other. A one-bit round-robin pointer inside the element picks the winner. The dropped request is not stored. Its input is flagged as blocked for that cycle, and the source must present it again later.

All columns are combinational. The delivered outputs and the per-input accept and blocked flags are registered once, so a request presented before one rising edge is visible after that edge.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and right after it, every `out_valid`, `in_accept` and `in_blocked` bit is 0.
- R2: Inputs sampled at a rising clock edge are reflected on all outputs right after that same edge, a latency of one register.
- R3: A payload that is delivered appears at the output whose index equals its destination tag. The tag is the plain binary output index, and its most significant bit steers the first column.
- R4: A valid request whose path shares no internal link with any other valid request in the same cycle is always delivered. As a result, the identity mapping and every uniform cyclic shift deliver all eight requests.
- R5: When two valid requests need the same link, at most one of them is delivered. When all inputs target a single output, exactly one is delivered.
- R6: Each element holds a one-bit pointer that starts by favouring its upper input and flips only in a cycle where the element resolved a conflict. Example: inputs 0 and 4 sending to outputs 0 and 1 collide in the first column. They win alternately, starting with input 0. A conflict-free cycle in between leaves the alternation unchanged.
- R7: An input whose valid is low produces no output, and it raises neither its accept flag nor its blocked flag.
- R8: For every valid input, exactly one of `in_accept` and `in_blocked` is raised in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Request present, one bit per input |
| in_tag | input | N*log2 N | Destination index per input, input i in bits [i*TW +: TW] |
| in_data | input | N*DW | Payload per input, input i in bits [i*DW +: DW] |
| out_valid | output | N | Payload delivered on output j |
| out_data | output | N*DW | Payload per output, output j in bits [j*DW +: DW] |
| in_accept | output | N | Request of input i was delivered |
| in_blocked | output | N | Request of input i lost a conflict and was dropped |

## Verification
The bench walks through all 40320 permutations on an eight-port network. For each one it computes the link every request uses after each column, so it can tell apart the requests that must be delivered from the pairs that cannot both be delivered. Random partial-valid patterns with repeated destinations exercise the blocked flags and check that invalid inputs stay silent. A many-to-one pattern pins down the single-winner case. Directed collisions in the first column show the round-robin order and show that the pointer holds through a cycle with no conflict, which separates it from a pointer that toggles every cycle.

// File: rtl/omega_pkg.sv
package omega_pkg;
   // Left rotate of a lane index by one position: the perfect-shuffle map.
   function automatic int shuffle_idx(input int idx, input int bits);
      int mask;
      mask = (1 << bits) - 1;
      return ((idx << 1) | (idx >> (bits - 1))) & mask;
   endfunction
endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
   parameter int N  = 8,
   parameter int LW = 16
) (
   input  logic [N*LW-1:0] lanes_in,
   output logic [N*LW-1:0] lanes_out
);
   localparam int TW = $clog2(N);

   for (genvar p = 0; p < N; p++) begin : g_wire
      localparam int Q = omega_pkg::shuffle_idx(p, TW);
      assign lanes_out[Q*LW +: LW] = lanes_in[p*LW +: LW];
   end
endmodule

// File: rtl/omega_switch.sv
module omega_switch #(
   parameter int LW    = 16,
   parameter int SEL   = 10,
   parameter bit RR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] in_up,
   input  logic [LW-1:0] in_lo,
   output logic [LW-1:0] out_up,
   output logic [LW-1:0] out_lo
);
   logic up_v, lo_v, up_b, lo_b;
   logic clash, favour_lo, up_go, lo_go;

   assign up_v  = in_up[LW-1];
   assign lo_v  = in_lo[LW-1];
   assign up_b  = in_up[SEL];
   assign lo_b  = in_lo[SEL];
   assign clash = up_v && lo_v && (up_b == lo_b);

   if (RR_EN) begin : g_rr
      always_ff @(posedge clk) begin
         if (!rst_n)     favour_lo <= 1'b0;
         else if (clash) favour_lo <= ~favour_lo;
      end

      assert_ptr_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
         clash |=> (favour_lo != $past(favour_lo)));
      assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !clash |=> $stable(favour_lo));
   end else begin : g_fixed
      assign favour_lo = 1'b0;
   end

   assign up_go = up_v && (!clash || !favour_lo);
   assign lo_go = lo_v && (!clash ||  favour_lo);

   always_comb begin
      out_up = '0;
      out_lo = '0;
      if (up_go) begin
         if (up_b) out_lo = in_up;
         else      out_up = in_up;
      end
      if (lo_go) begin
         if (lo_b) out_lo = in_lo;
         else      out_up = in_lo;
      end
   end

   assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> (out_up[LW-1] ^ out_lo[LW-1]) && (up_go != lo_go));
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
   parameter int N     = 8,
   parameter int LW    = 16,
   parameter int SEL   = 10,
   parameter bit RR_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N*LW-1:0] lanes_in,
   output logic [N*LW-1:0] lanes_out
);
   localparam int HALF = N / 2;

   logic [N*LW-1:0] shuffled;

   omega_shuffle #(.N(N), .LW(LW)) u_shuffle (
      .lanes_in  (lanes_in),
      .lanes_out (shuffled)
   );

   for (genvar k = 0; k < HALF; k++) begin : g_elem
      omega_switch #(.LW(LW), .SEL(SEL), .RR_EN(RR_EN)) u_sw (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_up  (shuffled[(2*k)*LW +: LW]),
         .in_lo  (shuffled[(2*k+1)*LW +: LW]),
         .out_up (lanes_out[(2*k)*LW +: LW]),
         .out_lo (lanes_out[(2*k+1)*LW +: LW])
      );
   end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
   parameter int N     = 8,
   parameter int DW    = 8,
   parameter bit RR_EN = 1'b1,
   localparam int TW   = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]    in_valid,
   input  logic [N*TW-1:0] in_tag,
   input  logic [N*DW-1:0] in_data,
   output logic [N-1:0]    out_valid,
   output logic [N*DW-1:0] out_data,
   output logic [N-1:0]    in_accept,
   output logic [N-1:0]    in_blocked
);
   // Lane layout: {valid, tag, source, payload}
   localparam int LW      = 1 + TW + TW + DW;
   localparam int SRC_LSB = DW;
   localparam int TAG_LSB = DW + TW;
   localparam int STAGES  = TW;

   if (N < 2 || (1 << TW) != N) begin : g_bad_n
      $error("omega_net: N must be a power of two, at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("omega_net: DW must be at least 1");
   end

   logic [N*LW-1:0] lanes [0:STAGES];

   for (genvar i = 0; i < N; i++) begin : g_inject
      assign lanes[0][i*LW +: LW] = {in_valid[i], in_tag[i*TW +: TW],
                                     TW'(i), in_data[i*DW +: DW]};
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      omega_stage #(.N(N), .LW(LW), .SEL(TAG_LSB + TW - 1 - s), .RR_EN(RR_EN)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .lanes_in  (lanes[s]),
         .lanes_out (lanes[s+1])
      );
   end

   logic [N-1:0]    fin_valid;
   logic [N*DW-1:0] fin_data;
   logic [N*TW-1:0] fin_tag;
   logic [N-1:0]    delivered;
   logic [N*TW-1:0] tag_q;

   for (genvar j = 0; j < N; j++) begin : g_extract
      assign fin_valid[j]           = lanes[STAGES][j*LW + LW - 1];
      assign fin_tag[j*TW +: TW]    = lanes[STAGES][j*LW + TAG_LSB +: TW];
      assign fin_data[j*DW +: DW]   = lanes[STAGES][j*LW +: DW];
   end

   always_comb begin
      delivered = '0;
      for (int j = 0; j < N; j++) begin
         if (fin_valid[j])
            delivered[lanes[STAGES][j*LW + SRC_LSB +: TW]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= '0;
         out_data   <= '0;
         tag_q      <= '0;
         in_accept  <= '0;
         in_blocked <= '0;
      end else begin
         out_valid  <= fin_valid;
         out_data   <= fin_data;
         tag_q      <= fin_tag;
         in_accept  <= in_valid & delivered;
         in_blocked <= in_valid & ~delivered;
      end
   end

   for (genvar j = 0; j < N; j++) begin : g_chk
      assert_tag_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[j] |-> (tag_q[j*TW +: TW] == TW'(j)));
      assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid[j] |=> (in_accept[j] ^ in_blocked[j]));
      assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid[j] |=> !in_accept[j] && !in_blocked[j]);
   end

   assert_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_valid) == $countones(in_accept));
endmodule

// File: tb/omega_net_tb.sv
module omega_net_tb;
   localparam int N  = 8;
   localparam int TW = 3;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]    in_valid = '0;
   logic [N*TW-1:0] in_tag = '0;
   logic [N*DW-1:0] in_data = '0;
   logic [N-1:0]    out_valid;
   logic [N*DW-1:0] out_data;
   logic [N-1:0]    in_accept;
   logic [N-1:0]    in_blocked;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   int d_v [N];
   int d_t [N];
   int d_d [N];

   always #5 clk = ~clk;

   omega_net #(.N(N), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .in_accept(in_accept), .in_blocked(in_blocked)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Position of the link used after column k by a request src->dst
   function automatic int link_pos(input int src, input int dst, input int k);
      return ((src << (k + 1)) | (dst >> (TW - 1 - k))) & (N - 1);
   endfunction

   function automatic bit share_link(input int a, input int b);
      for (int k = 0; k < TW; k++)
         if (link_pos(a, d_t[a], k) == link_pos(b, d_t[b], k)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic drive();
      for (int i = 0; i < N; i++) begin
         in_valid[i]           = d_v[i][0];
         in_tag[i*TW +: TW]    = d_t[i][TW-1:0];
         in_data[i*DW +: DW]   = d_d[i][DW-1:0];
      end
      @(posedge clk);
      #1;
   endtask

   // Generic per-cycle checks against the driven pattern
   task automatic check_all();
      bit ok;
      bit isolated;
      ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (d_v[i] != 0) begin
            if ((in_accept[i] ^ in_blocked[i]) != 1'b1) ok = 1'b0;
         end else if (in_accept[i] || in_blocked[i]) ok = 1'b0;
      end
      check(ok, "R8/R7", "accept/blocked flags", int'(in_accept), int'(in_blocked));
      ok = 1'b1;
      for (int i = 0; i < N; i++)
         if (in_accept[i] && !(out_valid[d_t[i]] &&
             out_data[d_t[i]*DW +: DW] == d_d[i][DW-1:0])) ok = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (out_valid[j]) begin
            bit found;
            found = 1'b0;
            for (int i = 0; i < N; i++)
               if (d_v[i] != 0 && d_t[i] == j && in_accept[i] &&
                   d_d[i][DW-1:0] == out_data[j*DW +: DW]) found = 1'b1;
            if (!found) ok = 1'b0;
         end
      end
      check(ok, "R3", "payload at tagged output", int'(out_valid), int'(in_accept));
      ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (d_v[i] != 0) begin
            isolated = 1'b1;
            for (int m = 0; m < N; m++)
               if (m != i && d_v[m] != 0 && share_link(i, m)) begin
                  isolated = 1'b0;
                  if (in_accept[i] && in_accept[m]) ok = 1'b0;
               end
            if (isolated && !in_accept[i]) ok = 1'b0;
         end
      end
      check(ok, "R4/R5", "isolated delivered, sharers not both", int'(in_accept), 0);
   endtask

   task automatic clear_pat();
      for (int i = 0; i < N; i++) begin
         d_v[i] = 0; d_t[i] = 0; d_d[i] = 0;
      end
   endtask

   task automatic rr_cycle(input int winner, input int loser, input int cyc);
      clear_pat();
      d_v[0] = 1; d_t[0] = 0; d_d[0] = 8'h10 + cyc;
      d_v[4] = 1; d_t[4] = 1; d_d[4] = 8'h40 + cyc;
      drive();
      check(in_accept[winner] && in_blocked[loser], "R6", "round-robin winner",
            int'(in_accept), 1 << winner);
      check_all();
   endtask

   initial begin
      int lfsr;
      int pool [N];
      int rest;
      int fact;
      clear_pat();
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 0 && in_accept == 0 && in_blocked == 0, "R1",
            "outputs in reset", int'({out_valid, in_accept, in_blocked}), 0);
      rst_n = 1'b1;
      #1;
      check(out_valid == 0 && in_accept == 0 && in_blocked == 0, "R1",
            "outputs after reset", int'({out_valid, in_accept, in_blocked}), 0);

      // R6: collisions in column 0, element 0
      rr_cycle(0, 4, 0);
      rr_cycle(4, 0, 1);
      clear_pat();
      d_v[0] = 1; d_t[0] = 0; d_d[0] = 8'h77;
      drive();
      check(in_accept == 8'h01 && out_valid == 8'h01 && out_data[7:0] == 8'h77,
            "R2", "single request one cycle later", int'(out_data[7:0]), 8'h77);
      rr_cycle(0, 4, 2);
      rr_cycle(4, 0, 3);

      // R7: invalid inputs with tags produce nothing
      clear_pat();
      for (int i = 0; i < N; i++) begin d_t[i] = i; d_d[i] = 8'hA0 + i; end
      drive();
      check(out_valid == 0 && in_accept == 0 && in_blocked == 0, "R7",
            "invalid inputs silent", int'(out_valid), 0);

      // R4: identity and uniform shifts
      for (int sh = 0; sh < N; sh++) begin
         for (int i = 0; i < N; i++) begin
            d_v[i] = 1; d_t[i] = (i + sh) % N; d_d[i] = (i * 29 + sh) & 8'hFF;
         end
         drive();
         check(in_accept == 8'hFF && out_valid == 8'hFF, "R4", "shift never blocks",
               int'(in_accept), 8'hFF);
         check_all();
      end

      // R5: many-to-one
      for (int dst = 0; dst < N; dst++) begin
         for (int i = 0; i < N; i++) begin
            d_v[i] = 1; d_t[i] = dst; d_d[i] = 8'hC0 + i;
         end
         drive();
         check($countones(in_accept) == 1 && $countones(in_blocked) == N - 1, "R5",
               "many-to-one single winner", $countones(in_accept), 1);
         check_all();
      end

      // All permutations, decoded from a factorial index
      for (int idx = 0; idx < 40320; idx++) begin
         for (int i = 0; i < N; i++) pool[i] = i;
         rest = idx;
         fact = 5040;
         for (int i = 0; i < N; i++) begin
            int pick;
            pick = rest / fact;
            rest = rest % fact;
            d_t[i] = pool[pick];
            for (int m = pick; m < N - 1 - i; m++) pool[m] = pool[m + 1];
            if (i < N - 1) fact = fact / (N - 1 - i);
            d_v[i] = 1;
            d_d[i] = (idx + i * 37) & 8'hFF;
         end
         drive();
         check_all();
      end

      // Random partial-valid patterns with repeated destinations
      lfsr = 32'h1ACE5;
      for (int c = 0; c < 3000; c++) begin
         for (int i = 0; i < N; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 0);
            d_v[i] = (lfsr >> 3) & 1;
            d_t[i] = (lfsr >> 7) & (N - 1);
            d_d[i] = (lfsr >> 12) & 8'hFF;
         end
         drive();
         check_all();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule